// File: doc/BRIEF.md
# USB Device Endpoint Handshake Responder

This block picks the handshake that a USB device sends back when a token reaches one of its endpoints. Endpoint 0 is the control endpoint and always exists. Five general slots each carry an enable, an endpoint number, a direction and a maximum packet size. A decoded token arrives with its type, endpoint number and the link speed. The block finds the slot that serves the token and compares that slot's FIFO level with the slot's maximum packet size. One cycle later it puts out a response code, together with a one-hot strobe that commits the received packet to the FIFO or throws it away.

When an IN token is answered with DATA, the block holds that slot pending. An acknowledgement from the host then pops the packet from the FIFO. High-speed flow control follows the free space in the FIFO. PING is answered from the free space. An OUT packet that leaves less than one maximum packet of room is answered NYET. A force-full-speed input turns off both PING and NYET.

Top module: `ep_handshake_responder`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_code` is 3'b000 and every bit of `commit_o`, `discard_o` and `pop_o` is 0.
- R2: An IN token (type 2'b00) to a slot whose data count is below its maximum packet size gets NAK. When the count is at least the maximum packet size it gets DATA. The code appears in the cycle after the token is sampled, and neither case gives a FIFO strobe.
- R3: After a DATA response, a host acknowledgement (`host_ack_valid` with `host_ack_ok` high) gives a one-cycle `pop_o` pulse on that slot in the following cycle. An acknowledgement with `host_ack_ok` low gives no pop. An acknowledgement with no DATA pending also gives no pop.
- R4: An OUT token (type 2'b01) whose slot has free space below its maximum packet size gets NAK and a `discard_o` pulse on that slot.
- R5: An accepted OUT (free space at least the maximum packet size) at full speed, or with `force_fs` high, gets ACK and a `commit_o` pulse on that slot.
- R6: In high-speed mode (`hs_link` high, `force_fs` low), an accepted OUT gets NYET if the free space minus the maximum packet size is below the maximum packet size, and ACK otherwise. It always gets a `commit_o` pulse.
- R7: In high-speed mode, a PING token (type 2'b10) gets ACK when the free space is at least the maximum packet size and NAK otherwise, with no FIFO strobe.
- R8: A PING at full speed, or with `force_fs` high, gets no response (code 3'b000).
- R9: A token gets no response and no strobe when its endpoint number matches no enabled slot, or matches only slots of the other direction.
- R10: Endpoint 0 serves IN, OUT and SETUP with the maximum packet size `EP0_MPS` (64 by default). A SETUP token (type 2'b11) to endpoint 0 gets ACK and a commit on slot 0 whatever the free space. A SETUP to any other endpoint gets no response.
- R11: The response codes are 3'b000 none, 3'b001 ACK, 3'b010 NAK, 3'b011 NYET and 3'b100 DATA. Strobe bit 0 is endpoint 0, and bit k is general slot k (1 to 5).
- R12: When several enabled slots match a token in both number and direction, the lowest-numbered slot serves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_type | input | 2 | 00 IN, 01 OUT, 10 PING, 11 SETUP |
| tok_ep | input | 4 | Endpoint number of the token |
| hs_link | input | 1 | Link runs at high speed |
| force_fs | input | 1 | Force full-speed behaviour (no PING, no NYET) |
| host_ack_valid | input | 1 | Host handshake phase after a DATA packet |
| host_ack_ok | input | 1 | Host returned ACK |
| cfg_en | input | 5 | Enable per general slot |
| cfg_in | input | 5 | Slot direction, 1 = IN |
| cfg_num | input | 20 | Endpoint number per slot, 4 bits each, slot 1 in the low bits |
| cfg_mps | input | 55 | Maximum packet size per slot, 11 bits each |
| fifo_cnt | input | 78 | FIFO data count per slot, 13 bits each, slot 0 in the low bits |
| fifo_free | input | 78 | FIFO free count per slot, 13 bits each |
| rsp_code | output | 3 | Response code |
| commit_o | output | 6 | Commit received packet, one-hot per slot |
| discard_o | output | 6 | Discard received packet, one-hot per slot |
| pop_o | output | 6 | Drop sent packet, one-hot per slot |

## Verification
The assertions take for granted that a host acknowledgement and a new token never come in the same cycle, and that the configuration and FIFO levels do not change while a token is being judged. The stimulus changes the inputs only at falling edges. It raises each token for exactly one cycle, and it drives acknowledgements only in cycles with no token. The configuration is changed only between tokens.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    typedef enum logic [1:0] {
        TK_IN    = 2'b00,
        TK_OUT   = 2'b01,
        TK_PING  = 2'b10,
        TK_SETUP = 2'b11
    } tok_e;

    typedef enum logic [2:0] {
        RS_NONE = 3'b000,
        RS_ACK  = 3'b001,
        RS_NAK  = 3'b010,
        RS_NYET = 3'b011,
        RS_DATA = 3'b100
    } rsp_e;

    typedef struct packed {
        rsp_e code;
        logic commit;
        logic discard;
        logic arm;
    } verdict_t;

    function automatic logic dir_fits(input logic slot_is_in, input tok_e t);
        case (t)
            TK_IN:            return slot_is_in;
            TK_OUT, TK_PING:  return !slot_is_in;
            default:          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hsr_slot_match.sv
module hsr_slot_match
    import hsr_pkg::*;
#(
    parameter int NUM_GEN = 5,
    parameter int EPW     = 4,
    localparam int IW     = $clog2(NUM_GEN + 1)
) (
    input  logic [EPW-1:0]         tok_ep,
    input  tok_e                   tok_type,
    input  logic [NUM_GEN-1:0]     cfg_en,
    input  logic [NUM_GEN-1:0]     cfg_in,
    input  logic [NUM_GEN*EPW-1:0] cfg_num,
    output logic                   hit,
    output logic [IW-1:0]          idx
);

    logic [NUM_GEN-1:0] slot_hit;

    for (genvar k = 0; k < NUM_GEN; k++) begin : g_slot
        assign slot_hit[k] = cfg_en[k]
                          && (cfg_num[k*EPW +: EPW] == tok_ep)
                          && dir_fits(cfg_in[k], tok_type);
    end

    // Endpoint 0 owns number zero; among general slots the lowest wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (tok_ep == '0) begin
            hit = 1'b1;
        end else begin
            for (int k = NUM_GEN - 1; k >= 0; k--) begin
                if (slot_hit[k]) begin
                    hit = 1'b1;
                    idx = IW'(k + 1);
                end
            end
        end
    end

endmodule

// File: rtl/hsr_verdict.sv
module hsr_verdict
    import hsr_pkg::*;
#(
    parameter int CW   = 13,
    parameter int MPSW = 11,
    localparam int XW  = ((CW > MPSW) ? CW : MPSW) + 1
) (
    input  logic            act,
    input  logic            is_ep0,
    input  tok_e            tok_type,
    input  logic            hs_eff,
    input  logic [MPSW-1:0] mps,
    input  logic [CW-1:0]   cnt,
    input  logic [CW-1:0]   free,
    output verdict_t        v
);

    logic [XW-1:0] mps_x, cnt_x, free_x, room_x;
    logic          data_ready, space_ok, tight;

    assign mps_x      = XW'(mps);
    assign cnt_x      = XW'(cnt);
    assign free_x     = XW'(free);
    assign data_ready = cnt_x >= mps_x;
    assign space_ok   = free_x >= mps_x;
    assign room_x     = space_ok ? (free_x - mps_x) : '0;
    assign tight      = room_x < mps_x;

    always_comb begin
        v      = '0;
        v.code = RS_NONE;
        if (act) begin
            case (tok_type)
                TK_IN: begin
                    if (data_ready) begin
                        v.code = RS_DATA;
                        v.arm  = 1'b1;
                    end else begin
                        v.code = RS_NAK;
                    end
                end
                TK_OUT: begin
                    if (!space_ok) begin
                        v.code    = RS_NAK;
                        v.discard = 1'b1;
                    end else begin
                        v.code   = (hs_eff && tight) ? RS_NYET : RS_ACK;
                        v.commit = 1'b1;
                    end
                end
                TK_PING: begin
                    if (hs_eff) v.code = space_ok ? RS_ACK : RS_NAK;
                end
                default: begin
                    if (is_ep0) begin
                        v.code   = RS_ACK;
                        v.commit = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ep_handshake_responder.sv
module ep_handshake_responder
    import hsr_pkg::*;
#(
    parameter int NUM_GEN = 5,
    parameter int EPW     = 4,
    parameter int CW      = 13,
    parameter int MPSW    = 11,
    parameter int EP0_MPS = 64,
    localparam int NS     = NUM_GEN + 1,
    localparam int IW     = $clog2(NUM_GEN + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tok_valid,
    input  logic [1:0]              tok_type,
    input  logic [EPW-1:0]          tok_ep,
    input  logic                    hs_link,
    input  logic                    force_fs,
    input  logic                    host_ack_valid,
    input  logic                    host_ack_ok,
    input  logic [NUM_GEN-1:0]      cfg_en,
    input  logic [NUM_GEN-1:0]      cfg_in,
    input  logic [NUM_GEN*EPW-1:0]  cfg_num,
    input  logic [NUM_GEN*MPSW-1:0] cfg_mps,
    input  logic [NS*CW-1:0]        fifo_cnt,
    input  logic [NS*CW-1:0]        fifo_free,
    output logic [2:0]              rsp_code,
    output logic [NS-1:0]           commit_o,
    output logic [NS-1:0]           discard_o,
    output logic [NS-1:0]           pop_o
);

    tok_e            ttype;
    logic            hit;
    logic [IW-1:0]   idx;
    logic [MPSW-1:0] slot_mps  [NS];
    logic [CW-1:0]   slot_cnt  [NS];
    logic [CW-1:0]   slot_free [NS];
    verdict_t        v;
    logic            hs_eff;

    logic [2:0]      rsp_q;
    logic [NS-1:0]   commit_q, discard_q, pop_q;
    logic            pend_q;
    logic [IW-1:0]   pend_idx_q;

    assign ttype  = tok_e'(tok_type);
    assign hs_eff = hs_link && !force_fs;

    for (genvar s = 0; s < NS; s++) begin : g_lvl
        assign slot_cnt[s]  = fifo_cnt[s*CW +: CW];
        assign slot_free[s] = fifo_free[s*CW +: CW];
        if (s == 0) begin : g_ep0
            assign slot_mps[s] = MPSW'(EP0_MPS);
        end else begin : g_gen
            assign slot_mps[s] = cfg_mps[(s-1)*MPSW +: MPSW];
        end
    end

    hsr_slot_match #(.NUM_GEN(NUM_GEN), .EPW(EPW)) u_match (
        .tok_ep   (tok_ep),
        .tok_type (ttype),
        .cfg_en   (cfg_en),
        .cfg_in   (cfg_in),
        .cfg_num  (cfg_num),
        .hit      (hit),
        .idx      (idx)
    );

    hsr_verdict #(.CW(CW), .MPSW(MPSW)) u_verdict (
        .act      (tok_valid && hit),
        .is_ep0   (idx == '0),
        .tok_type (ttype),
        .hs_eff   (hs_eff),
        .mps      (slot_mps[idx]),
        .cnt      (slot_cnt[idx]),
        .free     (slot_free[idx]),
        .v        (v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q      <= RS_NONE;
            commit_q   <= '0;
            discard_q  <= '0;
            pop_q      <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
        end else begin
            rsp_q     <= v.code;
            commit_q  <= v.commit  ? (NS'(1) << idx) : '0;
            discard_q <= v.discard ? (NS'(1) << idx) : '0;
            pop_q     <= (host_ack_valid && host_ack_ok && pend_q)
                         ? (NS'(1) << pend_idx_q) : '0;
            if (v.arm) begin
                pend_q     <= 1'b1;
                pend_idx_q <= idx;
            end else if (tok_valid || host_ack_valid) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign rsp_code  = rsp_q;
    assign commit_o  = commit_q;
    assign discard_o = discard_q;
    assign pop_o     = pop_q;

    // Assertions

    p_resp_after_token_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_code != 3'(RS_NONE)) |-> $past(tok_valid));

    p_pop_needs_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (|pop_o) |-> $past(host_ack_valid && host_ack_ok));

    p_discard_is_nak_r4: assert property (@(posedge clk) disable iff (rst)
        (|discard_o) |-> (rsp_code == 3'(RS_NAK)));

    p_commit_is_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (|commit_o) |-> (rsp_code == 3'(RS_ACK) || rsp_code == 3'(RS_NYET)));

    p_nyet_only_hs_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_code == 3'(RS_NYET)) |-> $past(hs_link && !force_fs));

    p_ping_only_hs_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(tok_valid && tok_type == 2'b10) && rsp_code != 3'(RS_NONE))
        |-> $past(hs_link && !force_fs));

    p_onehot_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(commit_o) && $onehot0(discard_o) && $onehot0(pop_o));

endmodule

// File: tb/ep_handshake_responder_test.sv
`timescale 1ns/1ps
module ep_handshake_responder_test;

    localparam int NG = 5;
    localparam int NS = 6;
    localparam int CW = 13;
    localparam int MW = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tok_valid = 1'b0;
    logic [1:0]      tok_type = '0;
    logic [3:0]      tok_ep = '0;
    logic            hs_link = 1'b0;
    logic            force_fs = 1'b0;
    logic            host_ack_valid = 1'b0;
    logic            host_ack_ok = 1'b0;
    logic [NG-1:0]   cfg_en;
    logic [NG-1:0]   cfg_in;
    logic [NG*4-1:0] cfg_num;
    logic [NG*MW-1:0] cfg_mps;
    logic [NS*CW-1:0] fifo_cnt = '0;
    logic [NS*CW-1:0] fifo_free = '0;
    logic [2:0]      rsp_code;
    logic [NS-1:0]   commit_o, discard_o, pop_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ep_handshake_responder uut (
        .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_type(tok_type),
        .tok_ep(tok_ep), .hs_link(hs_link), .force_fs(force_fs),
        .host_ack_valid(host_ack_valid), .host_ack_ok(host_ack_ok),
        .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_num(cfg_num), .cfg_mps(cfg_mps),
        .fifo_cnt(fifo_cnt), .fifo_free(fifo_free), .rsp_code(rsp_code),
        .commit_o(commit_o), .discard_o(discard_o), .pop_o(pop_o)
    );

    typedef struct packed {
        logic [1:0]  ty;
        logic [3:0]  ep;
        logic        hs;
        logic        ffs;
        logic [12:0] cnt;
        logic [12:0] fr;
        logic [2:0]  code;
        logic [2:0]  slot;
        logic [1:0]  kind;   // 0 none, 1 commit, 2 discard
    } vec_t;

    // Slots: 1 ep1 IN mps64, 2 ep2 OUT mps64, 3 ep3 IN mps32, 4 ep3 OUT mps16, 5 ep7 off
    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 4'd1, 1'b0, 1'b0, 13'd63,  13'd0,   3'd2, 3'd0, 2'd0}, // R2 NAK
        '{2'd0, 4'd1, 1'b0, 1'b0, 13'd64,  13'd0,   3'd4, 3'd0, 2'd0}, // R2 DATA
        '{2'd0, 4'd3, 1'b1, 1'b0, 13'd32,  13'd0,   3'd4, 3'd0, 2'd0}, // R2 DATA
        '{2'd0, 4'd3, 1'b1, 1'b0, 13'd31,  13'd0,   3'd2, 3'd0, 2'd0}, // R2 NAK
        '{2'd1, 4'd2, 1'b0, 1'b0, 13'd0,   13'd63,  3'd2, 3'd2, 2'd2}, // R4
        '{2'd1, 4'd2, 1'b0, 1'b0, 13'd0,   13'd64,  3'd1, 3'd2, 2'd1}, // R5
        '{2'd1, 4'd2, 1'b1, 1'b0, 13'd0,   13'd127, 3'd3, 3'd2, 2'd1}, // R6 NYET
        '{2'd1, 4'd2, 1'b1, 1'b0, 13'd0,   13'd128, 3'd1, 3'd2, 2'd1}, // R6 ACK
        '{2'd1, 4'd2, 1'b1, 1'b1, 13'd0,   13'd64,  3'd1, 3'd2, 2'd1}, // R5 forced
        '{2'd2, 4'd2, 1'b1, 1'b0, 13'd0,   13'd64,  3'd1, 3'd0, 2'd0}, // R7 ACK
        '{2'd2, 4'd2, 1'b1, 1'b0, 13'd0,   13'd63,  3'd2, 3'd0, 2'd0}, // R7 NAK
        '{2'd2, 4'd2, 1'b0, 1'b0, 13'd0,   13'd200, 3'd0, 3'd0, 2'd0}, // R8 fs
        '{2'd2, 4'd2, 1'b1, 1'b1, 13'd0,   13'd200, 3'd0, 3'd0, 2'd0}, // R8 forced
        '{2'd1, 4'd1, 1'b0, 1'b0, 13'd0,   13'd200, 3'd0, 3'd0, 2'd0}, // R9 dir
        '{2'd0, 4'd6, 1'b0, 1'b0, 13'd200, 13'd200, 3'd0, 3'd0, 2'd0}, // R9 none
        '{2'd1, 4'd3, 1'b1, 1'b0, 13'd0,   13'd31,  3'd3, 3'd4, 2'd1}, // R6 slot4
        '{2'd0, 4'd0, 1'b0, 1'b0, 13'd64,  13'd0,   3'd4, 3'd0, 2'd0}, // R10 IN
        '{2'd1, 4'd0, 1'b0, 1'b0, 13'd0,   13'd64,  3'd1, 3'd0, 2'd1}, // R10 OUT
        '{2'd3, 4'd0, 1'b1, 1'b0, 13'd0,   13'd0,   3'd1, 3'd0, 2'd1}, // R10 SETUP
        '{2'd3, 4'd2, 1'b1, 1'b0, 13'd0,   13'd200, 3'd0, 3'd0, 2'd0}, // R10 SETUP gen
        '{2'd0, 4'd7, 1'b0, 1'b0, 13'd200, 13'd200, 3'd0, 3'd0, 2'd0}  // R9 disabled
    };

    function automatic string vtag(input int i);
        case (i)
            0, 1, 2, 3:        return "R2";
            4:                 return "R4";
            5, 8:              return "R5";
            6, 7, 15:          return "R6";
            9, 10:             return "R7";
            11, 12:            return "R8";
            13, 14, 20:        return "R9";
            default:           return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send_tok(input logic [1:0] ty, input logic [3:0] ep,
                            input logic hs, input logic ffs,
                            input logic [12:0] cnt, input logic [12:0] fr);
        @(negedge clk);
        tok_type  = ty;
        tok_ep    = ep;
        hs_link   = hs;
        force_fs  = ffs;
        fifo_cnt  = {NS{cnt}};
        fifo_free = {NS{fr}};
        tok_valid = 1'b1;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic send_ack(input logic ok);
        @(negedge clk);
        host_ack_valid = 1'b1;
        host_ack_ok    = ok;
        @(negedge clk);
        host_ack_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cfg_en  = 5'b01111;
        cfg_in  = 5'b00101;
        cfg_num = {4'd7, 4'd3, 4'd3, 4'd2, 4'd1};
        cfg_mps = {11'd64, 11'd16, 11'd32, 11'd64, 11'd64};

        repeat (3) @(negedge clk);
        chk("R1", "code in reset", 32'(rsp_code), 0);
        chk("R1", "strobes in reset", 32'({commit_o, discard_o, pop_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "code after reset", 32'(rsp_code), 0);
        chk("R1", "strobes after reset", 32'({commit_o, discard_o, pop_o}), 0);

        // Table walk; codes follow R11 encoding
        for (int i = 0; i < NV; i++) begin
            logic [NS-1:0] ec, ed;
            send_tok(TBL[i].ty, TBL[i].ep, TBL[i].hs, TBL[i].ffs,
                     TBL[i].cnt, TBL[i].fr);
            ec = (TBL[i].kind == 2'd1) ? NS'(1) << TBL[i].slot : '0;
            ed = (TBL[i].kind == 2'd2) ? NS'(1) << TBL[i].slot : '0;
            chk(vtag(i), $sformatf("vec %0d code (R11)", i), 32'(rsp_code), 32'(TBL[i].code));
            chk(vtag(i), $sformatf("vec %0d commit", i), 32'(commit_o), 32'(ec));
            chk(vtag(i), $sformatf("vec %0d discard", i), 32'(discard_o), 32'(ed));
            chk(vtag(i), $sformatf("vec %0d pop", i), 32'(pop_o), 0);
        end

        // R3: ack after DATA pops slot 1
        send_tok(2'd0, 4'd1, 1'b1, 1'b0, 13'd100, 13'd0);
        chk("R3", "data code", 32'(rsp_code), 32'd4);
        send_ack(1'b1);
        chk("R3", "pop after ack", 32'(pop_o), 32'h02);
        @(negedge clk);
        chk("R3", "pop is one cycle", 32'(pop_o), 0);
        send_ack(1'b1);
        chk("R3", "no pop without pending", 32'(pop_o), 0);

        // R3: host did not acknowledge
        send_tok(2'd0, 4'd3, 1'b1, 1'b0, 13'd100, 13'd0);
        send_ack(1'b0);
        chk("R3", "no pop on failed ack", 32'(pop_o), 0);

        // R10: endpoint 0 DATA then pop on slot 0
        send_tok(2'd0, 4'd0, 1'b0, 1'b0, 13'd64, 13'd0);
        send_ack(1'b1);
        chk("R10", "ep0 pop", 32'(pop_o), 32'h01);

        // R12: slot 5 also ep1 IN, slot 1 must win
        @(negedge clk);
        cfg_en  = 5'b11111;
        cfg_in  = 5'b10101;
        cfg_num = {4'd1, 4'd3, 4'd3, 4'd2, 4'd1};
        send_tok(2'd0, 4'd1, 1'b0, 1'b0, 13'd64, 13'd0);
        chk("R12", "priority code", 32'(rsp_code), 32'd4);
        send_ack(1'b1);
        chk("R12", "priority pop slot", 32'(pop_o), 32'h02);

        // R12: slot 1 off, slot 5 serves
        @(negedge clk);
        cfg_en = 5'b11110;
        send_tok(2'd0, 4'd1, 1'b0, 1'b0, 13'd64, 13'd0);
        send_ack(1'b1);
        chk("R12", "fallback pop slot", 32'(pop_o), 32'h20);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule